// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block serializes bytes onto a single idle-high line using start/stop framing. A host writes a data byte, optionally with a ninth bit, into a one-entry holding register. A separate shift register sends the frame. While one frame is on the line, the next byte can wait in the holding register. It is then launched with no idle gap as soon as the current stop bit ends.

The bit period comes from a programmable divisor and a prescale, so a wide range of bit rates is possible from a single clock. The divisor is either its low eight bits or the full sixteen bits. The prescale is selected by two mode inputs.

The host sees two status flags:
- A buffer-empty flag, which can also raise an interrupt when enabled.
- A shifter-empty flag, which it polls.

Writes that arrive while the holding register is occupied are dropped and tallied in a saturating error counter. Dropping the transmit enable aborts everything in flight.

Top module: `sertx_top`

## Requirements
- R1: In 8-bit mode (`nineBitMode`=0) a frame is 10 bits: a low start bit, then `wrData` bit 0 through bit 7, then a high stop bit, each held for one bit period.
- R2: In 9-bit mode (`nineBitMode`=1) a frame is 11 bits. The value of `wrNinth` captured with the byte is sent after data bit 7 and before the stop bit.
- R3: One bit period lasts (D+1)×P clock cycles. D is `divisor[7:0]` when `wideDiv`=0 and the full `divisor` when `wideDiv`=1. P is 64 when `highSpeed`=`wideDiv`=0, 16 when exactly one of them is 1, and 4 when both are 1.
- R4: When `highSpeed` and `wideDiv` are both 1 and D is 0 or 1, the block uses D=2.
- R5: A byte written while a frame is shifting waits in the holding register. Its start bit begins in the cycle right after the previous stop bit ends, so consecutive frame starts are exactly one frame length apart.
- R6: `bufEmpty` is high after reset and while the block is disabled. After an accepted write it stays high for one more cycle and drops on the second clock edge after the write. It returns high when the held byte moves into the shift register, and nothing else clears it.
- R7: `shiftEmpty` is high exactly when no frame is being shifted. While it is high, `txLine` is high.
- R8: A write (`wrStrobe`=1 with `txEnable`=1) that arrives while the holding register is occupied is dropped and increments `wrErrCount`, which saturates at its maximum. Writes with `txEnable`=0 are dropped and not counted.
- R9: Clearing `txEnable` aborts the current frame and discards any held byte. After the next clock edge, `txLine`, `bufEmpty` and `shiftEmpty` are high, and re-enabling sends nothing until a new write.
- R10: `irqOut` is high exactly when `bufEmpty` and `irqEnable` are both high.
- R11: After reset, `txLine`=1, `bufEmpty`=1, `shiftEmpty`=1 and `wrErrCount`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Transmit enable; low aborts and flushes |
| nineBitMode | input | 1 | 1 selects 9-bit frames |
| highSpeed | input | 1 | Prescale select bit A |
| wideDiv | input | 1 | Prescale select bit B; 1 selects the full-width divisor |
| divisor | input | DIV_W (16) | Bit-rate divisor |
| irqEnable | input | 1 | Interrupt enable |
| wrStrobe | input | 1 | One-cycle write of a new byte |
| wrData | input | DATA_W (8) | Byte to send |
| wrNinth | input | 1 | Ninth bit written with the byte |
| txLine | output | 1 | Serial output, idle high |
| bufEmpty | output | 1 | Holding register empty flag |
| shiftEmpty | output | 1 | Shift register empty flag |
| irqOut | output | 1 | Buffer-empty interrupt |
| wrErrCount | output | ERR_W (8) | Saturating count of dropped writes |

## Verification
The assertions check several properties on every cycle:
- The line stays high whenever the shifter is empty.
- Disabling flushes all state after one edge.
- `bufEmpty` only ever falls two edges after a write.
- The error counter never decreases and moves only after an enabled write.
- The interrupt stays low while it is disabled.

Properties that span a whole frame need the bench's scenarios:
- Bit order and the ninth bit.
- The exact period in each prescale mode, including the low-divisor clamp and the ignored upper divisor byte.
- Back-to-back launch spacing.
- Discarding of a held byte on abort.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int PRESCALE_SLOW = 64;
  localparam int PRESCALE_MID  = 16;
  localparam int PRESCALE_FAST = 4;
  localparam int MIN_FAST_DIV  = 2;
  localparam int SUB_W         = $clog2(PRESCALE_SLOW);

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } txState_t;

  typedef struct packed {
    logic holdLoad;   // capture host byte into holding register
    logic loadShift;  // move holding register into shifter
    logic shiftBit;   // advance shifter by one bit
    logic endFrame;   // frame over, nothing pending: park line high
    logic flush;      // enable dropped: clear everything
  } txStrobes_t;

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud
  import sertx_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic             highSpeed,
  input  logic             wideDiv,
  input  logic [DIV_W-1:0] divisor,
  output logic             bitEnd
);

  logic [DIV_W-1:0] divNarrow;
  logic [DIV_W-1:0] divSel;
  logic [DIV_W-1:0] divEff;
  logic [DIV_W-1:0] clkCnt;
  logic [SUB_W-1:0] subCnt;
  logic [SUB_W-1:0] subLimit;
  logic             tick;

  generate
    if (DIV_W > NARROW_W) begin : g_pad
      assign divNarrow = {{(DIV_W-NARROW_W){1'b0}}, divisor[NARROW_W-1:0]};
    end else begin : g_same
      assign divNarrow = divisor;
    end
  endgenerate

  always_comb begin
    divSel = wideDiv ? divisor : divNarrow;
    if (highSpeed && wideDiv && (divSel < DIV_W'(MIN_FAST_DIV)))
      divEff = DIV_W'(MIN_FAST_DIV);
    else
      divEff = divSel;
  end

  always_comb begin
    unique case ({highSpeed, wideDiv})
      2'b00:   subLimit = SUB_W'(PRESCALE_SLOW - 1);
      2'b11:   subLimit = SUB_W'(PRESCALE_FAST - 1);
      default: subLimit = SUB_W'(PRESCALE_MID - 1);
    endcase
  end

  assign tick   = (clkCnt >= divEff);
  assign bitEnd = tick && (subCnt >= subLimit);

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      clkCnt <= '0;
      subCnt <= '0;
    end else if (tick) begin
      clkCnt <= '0;
      subCnt <= (subCnt >= subLimit) ? '0 : subCnt + 1'b1;
    end else begin
      clkCnt <= clkCnt + 1'b1;
    end
  end

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEnable,
  input  logic             wrStrobe,
  input  logic             bitEnd,
  input  logic             lastBit,
  output txStrobes_t       strb,
  output logic             restart,
  output logic             bufEmpty,
  output logic             shiftEmpty,
  output logic [ERR_W-1:0] wrErrCount
);

  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  txState_t   state;
  logic       holdValid;
  logic       wrAccD;
  logic       bufEmptyQ;
  logic [ERR_W-1:0] errCnt;

  logic wrAccept;
  logic wrReject;
  logic frameDone;
  logic xfer;

  always_comb begin
    wrAccept  = txEnable && wrStrobe && !holdValid;
    wrReject  = txEnable && wrStrobe && holdValid;
    frameDone = (state == ST_SHIFT) && bitEnd && lastBit;
    xfer      = txEnable && holdValid && ((state == ST_IDLE) || frameDone);

    strb.holdLoad  = wrAccept;
    strb.loadShift = xfer;
    strb.shiftBit  = txEnable && (state == ST_SHIFT) && bitEnd && !lastBit;
    strb.endFrame  = txEnable && frameDone && !xfer;
    strb.flush     = !txEnable;
  end

  assign restart = xfer || (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN || !txEnable) begin
      state     <= ST_IDLE;
      holdValid <= 1'b0;
      wrAccD    <= 1'b0;
      bufEmptyQ <= 1'b1;
    end else begin
      wrAccD <= wrAccept;
      if (xfer)
        state <= ST_SHIFT;
      else if (frameDone)
        state <= ST_IDLE;
      if (wrAccept)
        holdValid <= 1'b1;
      else if (xfer)
        holdValid <= 1'b0;
      if (xfer)
        bufEmptyQ <= 1'b1;
      else if (wrAccD)
        bufEmptyQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      errCnt <= '0;
    else if (wrReject && (errCnt != ERR_MAX))
      errCnt <= errCnt + 1'b1;
  end

  assign bufEmpty   = bufEmptyQ;
  assign shiftEmpty = (state == ST_IDLE);
  assign wrErrCount = errCnt;

endmodule

// File: rtl/sertx_dp.sv
module sertx_dp
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strb,
  input  logic              nineBitMode,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrNinth,
  output logic              txLine,
  output logic              lastBit
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic [DATA_W-1:0]  holdData;
  logic               holdNinth;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bitsLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdData  <= '0;
      holdNinth <= 1'b0;
    end else if (strb.holdLoad) begin
      holdData  <= wrData;
      holdNinth <= wrNinth;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush || strb.endFrame) begin
      shreg    <= '1;
      bitsLeft <= '0;
    end else if (strb.loadShift) begin
      shreg    <= {1'b1, (nineBitMode ? holdNinth : 1'b1), holdData, 1'b0};
      bitsLeft <= nineBitMode ? CNT_W'(FRAME_W - 1) : CNT_W'(FRAME_W - 2);
    end else if (strb.shiftBit) begin
      shreg    <= {1'b1, shreg[FRAME_W-1:1]};
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  assign txLine  = shreg[0];
  assign lastBit = (bitsLeft == '0);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              nineBitMode,
  input  logic              highSpeed,
  input  logic              wideDiv,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              irqEnable,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrNinth,
  output logic              txLine,
  output logic              bufEmpty,
  output logic              shiftEmpty,
  output logic              irqOut,
  output logic [ERR_W-1:0]  wrErrCount
);

  txStrobes_t strb;
  logic       bitEnd;
  logic       lastBit;
  logic       restart;

  sertx_baud #(.DIV_W(DIV_W), .NARROW_W(8)) u_baud (
    .clk(clk), .rstN(rstN), .restart(restart),
    .highSpeed(highSpeed), .wideDiv(wideDiv), .divisor(divisor),
    .bitEnd(bitEnd)
  );

  sertx_ctrl #(.ERR_W(ERR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .wrStrobe(wrStrobe),
    .bitEnd(bitEnd), .lastBit(lastBit), .strb(strb), .restart(restart),
    .bufEmpty(bufEmpty), .shiftEmpty(shiftEmpty), .wrErrCount(wrErrCount)
  );

  sertx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .nineBitMode(nineBitMode),
    .wrData(wrData), .wrNinth(wrNinth), .txLine(txLine), .lastBit(lastBit)
  );

  assign irqOut = bufEmpty && irqEnable;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             txEnable,
  input logic             wrStrobe,
  input logic             irqEnable,
  input logic             txLine,
  input logic             bufEmpty,
  input logic             shiftEmpty,
  input logic             irqOut,
  input logic [ERR_W-1:0] wrErrCount
);

  // R7
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftEmpty |-> txLine);

  // R9
  disable_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (bufEmpty && shiftEmpty && txLine));

  // R6
  late_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufEmpty) |-> ($past(wrStrobe, 2) && $past(txEnable, 2)));

  // R8
  err_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrErrCount >= $past(wrErrCount));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrErrCount != $past(wrErrCount)) |-> $past(wrStrobe && txEnable));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irqOut);

endmodule

bind sertx_top sertx_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rstN(rstN), .txEnable(txEnable), .wrStrobe(wrStrobe),
  .irqEnable(irqEnable), .txLine(txLine), .bufEmpty(bufEmpty),
  .shiftEmpty(shiftEmpty), .irqOut(irqOut), .wrErrCount(wrErrCount)
);

// File: tb/sertx_top_tb.sv
`timescale 1ns/1ps
module sertx_top_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        txEnable, nineBitMode, highSpeed, wideDiv, irqEnable;
  logic [15:0] divisor;
  logic        wrStrobe, wrNinth;
  logic [7:0]  wrData;
  logic        txLine, bufEmpty, shiftEmpty, irqOut;
  logic [7:0]  wrErrCount;

  always #2 clk = ~clk;

  sertx_top u_dut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .nineBitMode(nineBitMode),
    .highSpeed(highSpeed), .wideDiv(wideDiv), .divisor(divisor),
    .irqEnable(irqEnable), .wrStrobe(wrStrobe), .wrData(wrData),
    .wrNinth(wrNinth), .txLine(txLine), .bufEmpty(bufEmpty),
    .shiftEmpty(shiftEmpty), .irqOut(irqOut), .wrErrCount(wrErrCount)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  int expErr = 0;

  int curT = 12;
  int curLen = 10;
  logic [10:0] rxQ[$];
  int          rxStart[$];
  logic [10:0] expQ[$];

  // line monitor: samples each bit at its centre
  bit          monBusy = 0;
  int          monStart, monOff, monIdx;
  logic [10:0] monVec;
  always @(negedge clk) begin
    if (rstN !== 1'b1 || txEnable !== 1'b1) begin
      monBusy = 0;
    end else if (!monBusy) begin
      if (txLine === 1'b0) begin
        monBusy  = 1;
        monStart = cyc;
        monVec   = '1;
      end
    end else begin
      monOff = cyc - monStart;
      if (monOff % curT == curT / 2) begin
        monIdx = monOff / curT;
        monVec[monIdx] = txLine;
        if (monIdx == curLen - 1) begin
          rxQ.push_back(monVec);
          rxStart.push_back(monStart);
          monBusy = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int periodOf(input bit hs, input bit wd, input logic [15:0] dv);
    int d;
    int p;
    d = wd ? int'(dv) : int'(dv[7:0]);
    if (hs && wd && d < 2) d = 2;
    p = (hs && wd) ? 4 : ((hs || wd) ? 16 : 64);
    return (d + 1) * p;
  endfunction

  function automatic logic [10:0] expFrame(input logic [7:0] d, input bit n9, input bit nine);
    logic [10:0] v;
    v = '1;
    v[0] = 1'b0;
    v[8:1] = d;
    if (nine) v[9] = n9;
    return v;
  endfunction

  task automatic setCfg(input bit hs, input bit wd, input logic [15:0] dv, input bit nine);
    @(negedge clk);
    highSpeed = hs; wideDiv = wd; divisor = dv; nineBitMode = nine;
    curT = periodOf(hs, wd, dv);
    curLen = nine ? 11 : 10;
  endtask

  task automatic wrByte(input logic [7:0] d, input bit n9);
    @(negedge clk);
    wrStrobe = 1'b1; wrData = d; wrNinth = n9;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (2) @(negedge clk);
    while (shiftEmpty !== 1'b1) @(negedge clk);
  endtask

  task automatic compareFrames(input string tag, input bit checkGap);
    chk(rxQ.size() == expQ.size(), {tag, " frame count"}, rxQ.size(), expQ.size());
    for (int i = 0; i < rxQ.size() && i < expQ.size(); i++)
      chk(rxQ[i] === expQ[i], {tag, " frame bits"}, rxQ[i], expQ[i]);
    if (checkGap)
      for (int i = 1; i < rxStart.size(); i++)
        chk(rxStart[i] - rxStart[i-1] == curLen * curT, {tag, " R5 start spacing"},
            rxStart[i] - rxStart[i-1], curLen * curT);
    rxQ.delete(); rxStart.delete(); expQ.delete();
  endtask

  task automatic sendPair(input logic [7:0] d0, input bit n0,
                          input logic [7:0] d1, input bit n1, input string tag);
    wrByte(d0, n0);
    repeat (3) @(negedge clk);
    wrByte(d1, n1);
    expQ.push_back(expFrame(d0, n0, nineBitMode));
    expQ.push_back(expFrame(d1, n1, nineBitMode));
    waitIdle();
    compareFrames(tag, 1);
  endtask

  task automatic sendStream(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      bit n9;
      d  = 8'($urandom_range(0, 255));
      n9 = 1'($urandom_range(0, 1));
      while (bufEmpty !== 1'b1) @(negedge clk);
      wrByte(d, n9);
      expQ.push_back(expFrame(d, n9, nineBitMode));
      @(negedge clk);
    end
    waitIdle();
    compareFrames(tag, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; txEnable = 1'b0; nineBitMode = 1'b0; highSpeed = 1'b1;
    wideDiv = 1'b1; divisor = 16'd2; irqEnable = 1'b0;
    wrStrobe = 1'b0; wrNinth = 1'b0; wrData = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(txLine === 1'b1, "R11 txLine", txLine, 1);
    chk(bufEmpty === 1'b1, "R11 bufEmpty", bufEmpty, 1);
    chk(shiftEmpty === 1'b1, "R11 shiftEmpty", shiftEmpty, 1);
    chk(wrErrCount === 8'd0, "R11 wrErrCount", wrErrCount, 0);

    // R1 R6 R8 R10: basic frame, buffering, dropped write, interrupt
    setCfg(1, 1, 16'd2, 0);
    txEnable = 1'b1; irqEnable = 1'b1;
    @(negedge clk);
    chk(bufEmpty === 1'b1, "R6 high on enable", bufEmpty, 1);
    chk(irqOut === 1'b1, "R10 irq with empty buffer", irqOut, 1);
    wrByte(8'hA5, 0);
    @(negedge clk);
    chk(shiftEmpty === 1'b0, "R7 shifter busy after load", shiftEmpty, 0);
    chk(txLine === 1'b0, "R1 start bit low", txLine, 0);
    repeat (5) @(negedge clk);
    wrByte(8'h3C, 0);
    chk(bufEmpty === 1'b1, "R6 still high one cycle after write", bufEmpty, 1);
    @(negedge clk);
    chk(bufEmpty === 1'b0, "R6 low two cycles after write", bufEmpty, 0);
    chk(irqOut === 1'b0, "R10 irq low with full buffer", irqOut, 0);
    wrByte(8'hFF, 0);
    expErr++;
    chk(wrErrCount == 8'(expErr), "R8 dropped write counted", wrErrCount, expErr);
    expQ.push_back(expFrame(8'hA5, 0, 0));
    expQ.push_back(expFrame(8'h3C, 0, 0));
    waitIdle();
    chk(bufEmpty === 1'b1, "R6 high after transfer", bufEmpty, 1);
    compareFrames("R1 R8 basic", 1);
    irqEnable = 1'b0;
    @(negedge clk);
    chk(irqOut === 1'b0, "R10 irq masked", irqOut, 0);

    // R4 clamp of small divisors in the fastest mode
    setCfg(1, 1, 16'd0, 0);
    sendPair(8'h01, 0, 8'h80, 0, "R4 div0");
    setCfg(1, 1, 16'd1, 0);
    sendPair(8'h5A, 0, 8'hC3, 0, "R4 div1");
    setCfg(1, 1, 16'd3, 0);
    sendPair(8'h96, 0, 8'h69, 0, "R3 fast div3");

    // R3 prescale modes and divisor width
    setCfg(1, 0, 16'h0103, 0);
    sendPair(8'hF0, 0, 8'h0F, 0, "R3 narrow ignores upper byte");
    setCfg(0, 0, 16'd0, 0);
    sendPair(8'h12, 0, 8'h34, 0, "R3 slow prescale");
    setCfg(0, 1, 16'd2, 0);
    sendPair(8'hAB, 0, 8'hCD, 0, "R3 mid prescale wide");
    setCfg(1, 1, 16'h0100, 0);
    sendPair(8'hE7, 0, 8'h18, 0, "R3 wide uses upper byte");

    // R2 nine-bit frames
    setCfg(1, 1, 16'd2, 1);
    sendPair(8'h5A, 1, 8'hC3, 0, "R2 ninth bit");

    // R9 abort discards frame and held byte
    setCfg(1, 1, 16'd3, 0);
    wrByte(8'h81, 0);
    repeat (3) @(negedge clk);
    wrByte(8'h7E, 0);
    repeat (20) @(negedge clk);
    txEnable = 1'b0;
    @(negedge clk);
    chk(txLine === 1'b1, "R9 line high after abort", txLine, 1);
    chk(bufEmpty === 1'b1, "R9 buffer empty after abort", bufEmpty, 1);
    chk(shiftEmpty === 1'b1, "R9 shifter empty after abort", shiftEmpty, 1);
    txEnable = 1'b1;
    repeat (2 * curLen * curT) @(negedge clk);
    chk(rxQ.size() == 0, "R9 nothing sent after re-enable", rxQ.size(), 0);
    chk(shiftEmpty === 1'b1, "R9 stays idle", shiftEmpty, 1);
    rxQ.delete(); rxStart.delete();

    // R8 writes while disabled are dropped and not counted
    txEnable = 1'b0;
    wrByte(8'h11, 0);
    txEnable = 1'b1;
    repeat (2 * curLen * curT) @(negedge clk);
    chk(rxQ.size() == 0, "R8 disabled write not sent", rxQ.size(), 0);
    chk(wrErrCount == 8'(expErr), "R8 disabled write not counted", wrErrCount, expErr);

    // R1 R2 R3 R5 random configurations, streamed frames
    for (int it = 0; it < 8; it++) begin
      bit hs, wd, nine;
      logic [15:0] dv;
      hs = 1'($urandom_range(0, 1));
      wd = 1'($urandom_range(0, 1));
      nine = 1'($urandom_range(0, 1));
      dv = 16'($urandom_range(0, 3));
      setCfg(hs, wd, dv, nine);
      sendStream(3, "R1 R2 R3 random stream");
    end

    // R8 saturation of the error counter
    setCfg(0, 0, 16'd0, 0);
    wrByte(8'h55, 0);
    repeat (3) @(negedge clk);
    wrByte(8'hAA, 0);
    @(negedge clk) wrStrobe = 1'b1; wrData = 8'h00;
    repeat (300) @(negedge clk);
    wrStrobe = 1'b0;
    @(negedge clk);
    chk(wrErrCount === 8'd255, "R8 counter saturates", wrErrCount, 255);
    expQ.push_back(expFrame(8'h55, 0, 0));
    expQ.push_back(expFrame(8'hAA, 0, 0));
    waitIdle();
    compareFrames("R8 frames around flood", 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule